// File: doc/BRIEF.md
# Shared Flash Lock Arbiter

This block hands out exclusive ownership of a serial flash that is worked by bit-banging. Four clients share the flash: two network-port drivers, a boot-ROM agent and firmware. Each client raises a request and waits for its grant. Only one client holds the grant at a time. The grant output is also that client's ownership status, so a client that has been quiet for a while can check it before it goes on toggling the flash pins.

While a client owns the flash, it drives toggle strobes each time it moves a flash pin. The arbiter counts the clock cycles since the holder's last strobe. If the timeout enable is set and the holder stays idle for the configured number of cycles, the arbiter withdraws the grant and raises a one-cycle timeout pulse. A stuck client therefore cannot lock the others out for good. A client that lost its grant this way must drop its request and raise it again before it can be served.

Waiting clients are served in the order their requests arrived. Requests that arrive in the same cycle are ordered by fixed priority.

Top module: `flash_lock_arb`

## Requirements
- R1: While reset is asserted, and at the first clock edge after it, all grant bits and the timeout pulse are 0.
- R2: At most one grant bit is set at any time. While one client holds the grant, every other requester keeps its grant bit at 0.
- R3: When no client holds the grant, a requesting client that is eligible gets its grant bit at the first clock edge at which its request is sampled high.
- R4: When the holder's request is sampled low, its grant clears at that edge. The next eligible waiting requester is granted at the following edge, so the grant vector is all zero for at least one cycle between two owners.
- R5: Among waiting clients, a request that was raised in an earlier cycle is granted before a request raised in a later cycle.
- R6: Requests first sampled in the same cycle are ordered by fixed priority, highest first: firmware (bit 3), port 0 driver (bit 0), port 1 driver (bit 1), boot-ROM agent (bit 2).
- R7: With the timeout enable high, suppose the holder keeps requesting but has no toggle sampled high for TIMEOUT_CYCLES consecutive edges, counted from the edge that granted it. Then the grant clears at the TIMEOUT_CYCLES-th edge, and the timeout pulse is high for exactly the one cycle that follows that edge.
- R8: A toggle strobe from the holder sampled at an edge restarts the count. The revocation then happens TIMEOUT_CYCLES edges after that edge.
- R9: Toggle strobes from clients that do not hold the grant have no effect on the holder's timeout.
- R10: With the timeout enable low, a grant is never withdrawn for inactivity and the timeout pulse stays 0.
- R11: A client whose grant was withdrawn for inactivity is not granted again while its request stays high. After it drops the request and raises it again, it can be granted normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, asynchronous assert |
| req_i | input | 4 | Per-client lock request (bit 0 port 0, bit 1 port 1, bit 2 boot-ROM, bit 3 firmware) |
| toggle_i | input | 4 | Per-client strobe, high in a cycle where that client moved a flash pin |
| timeout_en_i | input | 1 | Enables the inactivity revocation |
| grant_o | output | 4 | One-hot-or-zero grant; also the per-client ownership status |
| timeout_o | output | 1 | One-cycle pulse when a grant is withdrawn for inactivity |

## Verification
Arbitration is exercised in several ways. Simultaneous request sets probe the fixed priority alone. Staggered arrivals placed behind a busy holder probe arrival order, because arrival order and fixed priority would pick different winners there. Successive releases probe the idle gap between owners. For the timeout, one run has the holder silent while a non-holder toggles: the revocation edge matches a run with no toggles at all. Another run has the holder strobe once partway through; the revocation edge then moves later by the exact number of cycles, which separates a counter that reloads from one that does not. A run with the enable low confirms the grant survives several timeout lengths. A revoked client is held off until it drops its request and asks again.

// File: rtl/flash_lock_pkg.sv
package flash_lock_pkg;

   localparam int unsigned NC = 4;

   localparam int unsigned IDX_PORT0 = 0;
   localparam int unsigned IDX_PORT1 = 1;
   localparam int unsigned IDX_BOOT  = 2;
   localparam int unsigned IDX_FW    = 3;

   typedef logic [NC-1:0] cvec_t;

   // smaller rank wins among same-cycle arrivals
   function automatic int unsigned prio_rank(int unsigned idx);
      case (idx)
         IDX_FW:    return 0;
         IDX_PORT0: return 1;
         IDX_PORT1: return 2;
         default:   return 3;
      endcase
   endfunction

endpackage

// File: rtl/fla_order.sv
module fla_order
   import flash_lock_pkg::*;
(
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  cvec_t                   req_i,
   output logic [NC-1:0][NC-1:0]   older_o
);

   cvec_t                  seen_q;
   logic [NC-1:0][NC-1:0]  older_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         seen_q  <= '0;
         older_q <= '0;
      end else begin
         seen_q  <= req_i;
         older_q <= older_o;
      end
   end

   // older_o[i][j]: client i has been waiting longer than client j
   for (genvar i = 0; i < NC; i++) begin : g_row
      for (genvar j = 0; j < NC; j++) begin : g_col
         if (i == j) begin : g_diag
            assign older_o[i][j] = 1'b0;
         end else begin : g_pair
            localparam logic RANK_WIN = (prio_rank(i) < prio_rank(j));
            assign older_o[i][j] = (seen_q[i] && seen_q[j]) ? older_q[i][j] :
                                   seen_q[i]                ? 1'b1          :
                                   seen_q[j]                ? 1'b0          :
                                                              RANK_WIN;
         end
      end
   end

   // R5
   for (genvar i = 0; i < NC; i++) begin : g_asym
      for (genvar j = i + 1; j < NC; j++) begin : g_asym_col
         order_asym_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !(older_o[i][j] && older_o[j][i]));
      end
   end

endmodule

// File: rtl/fla_pick.sv
module fla_pick
   import flash_lock_pkg::*;
(
   input  cvec_t                  cand_i,
   input  logic [NC-1:0][NC-1:0]  older_i,
   output cvec_t                  win_o
);

   for (genvar i = 0; i < NC; i++) begin : g_win
      cvec_t beats;
      for (genvar j = 0; j < NC; j++) begin : g_beat
         assign beats[j] = older_i[j][i];
      end
      assign win_o[i] = cand_i[i] && !(|(cand_i & beats));
   end

endmodule

// File: rtl/fla_idle_timer.sv
module fla_idle_timer #(
   parameter int unsigned TIMEOUT_CYCLES = 16,
   localparam int unsigned CW = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic load_i,
   input  logic run_i,
   input  logic kick_i,
   input  logic en_i,
   output logic expire_o
);

   localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i || kick_i) begin
         cnt_q <= '0;
      end else if (run_i && (cnt_q != LAST)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expire_o = en_i && run_i && !kick_i && (cnt_q == LAST);

   // R7
   cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= LAST);

   // R8
   kick_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      kick_i |=> (cnt_q == '0));

endmodule

// File: rtl/flash_lock_arb.sv
module flash_lock_arb
   import flash_lock_pkg::*;
#(
   parameter int unsigned CLK_HZ         = 125_000_000,
   parameter int unsigned TIMEOUT_CYCLES = 2 * CLK_HZ
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [NC-1:0] req_i,
   input  logic [NC-1:0] toggle_i,
   input  logic          timeout_en_i,
   output logic [NC-1:0] grant_o,
   output logic          timeout_o
);

   if (TIMEOUT_CYCLES < 2) begin : g_bad_timeout
      $error("TIMEOUT_CYCLES must be at least 2");
   end
   if (NC != 4) begin : g_bad_clients
      $error("client count must be four");
   end

   cvec_t                  grant_q;
   cvec_t                  blocked_q;
   logic                   tmo_q;
   cvec_t                  cand;
   cvec_t                  win;
   logic [NC-1:0][NC-1:0]  older;
   logic                   holding;
   logic                   holder_req;
   logic                   holder_kick;
   logic                   release_now;
   logic                   expire;
   logic                   grant_set;

   assign holding     = |grant_q;
   assign holder_req  = |(grant_q & req_i);
   assign holder_kick = |(grant_q & toggle_i);
   assign release_now = holding && !holder_req;
   assign cand        = req_i & ~blocked_q;
   assign grant_set   = !holding && (|win);

   fla_order u_order (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (req_i),
      .older_o (older)
   );

   fla_pick u_pick (
      .cand_i  (cand),
      .older_i (older),
      .win_o   (win)
   );

   fla_idle_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (grant_set),
      .run_i    (holding && holder_req),
      .kick_i   (holder_kick),
      .en_i     (timeout_en_i),
      .expire_o (expire)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         grant_q   <= '0;
         blocked_q <= '0;
         tmo_q     <= 1'b0;
      end else begin
         tmo_q     <= expire;
         blocked_q <= (blocked_q & req_i) | (expire ? grant_q : '0);
         if (holding) begin
            if (release_now || expire) grant_q <= '0;
         end else begin
            grant_q <= win;
         end
      end
   end

   assign grant_o   = grant_q;
   assign timeout_o = tmo_q;

   // R2
   one_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(grant_q));

   // R4
   handoff_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((|grant_q) && (grant_q != $past(grant_q))) |-> ($past(grant_q) == '0));

   // R3
   grant_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_q & ~$past(grant_q) & ~$past(req_i)) == '0);

   // R11
   blocked_no_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_q & ~$past(grant_q) & $past(blocked_q)) == '0);

   // R7
   pulse_drops_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      timeout_o |-> ((grant_q == '0) && $past(|grant_q)));

   // R7
   single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      timeout_o |=> !timeout_o);

   // R10
   pulse_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      timeout_o |-> $past(timeout_en_i));

endmodule

// File: tb/flash_lock_arb_bench.sv
`timescale 1ns/1ps
module flash_lock_arb_bench;

   localparam int unsigned T = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] req = '0;
   logic [3:0] tog = '0;
   logic       en = 1'b0;
   logic [3:0] grant;
   logic       tmo;

   always #2.5 clk = ~clk;

   flash_lock_arb #(.CLK_HZ(1000), .TIMEOUT_CYCLES(T)) u_flash_lock_arb (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .req_i        (req),
      .toggle_i     (tog),
      .timeout_en_i (en),
      .grant_o      (grant),
      .timeout_o    (tmo)
   );

   typedef struct {
      int         cyc;
      logic [3:0] g;
      logic       t;
      string      tag;
   } item_t;

   item_t sb[$];
   int    cyc = 0;
   int    n_cmp = 0;
   int    n_bad = 0;

   task automatic expect_at(int d, logic [3:0] g, logic t, string tag);
      item_t it;
      it.cyc = cyc + d;
      it.g   = g;
      it.t   = t;
      it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_now(logic [3:0] g, logic t, string tag);
      n_cmp++;
      if (grant !== g || tmo !== t) begin
         n_bad++;
         $display("FAIL %s: grant=%b tmo=%b expected grant=%b tmo=%b", tag, grant, tmo, g, t);
      end
   endtask

   // monitor: pops scoreboard items due in this cycle
   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         #1;
         for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].cyc == cyc) begin
               chk_now(sb[i].g, sb[i].t, sb[i].tag);
               sb.delete(i);
            end
         end
      end
   end

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #(200000 * 5);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
   end

   initial begin
      step(3);
      chk_now(4'b0000, 1'b0, "R1 in reset");
      rst_n = 1'b1;
      expect_at(1, 4'b0000, 1'b0, "R1 after reset");
      step(2);

      // R6: three same-cycle arrivals, port 0 wins
      req = 4'b0111;
      expect_at(1, 4'b0001, 1'b0, "R6 port0 first");
      expect_at(3, 4'b0001, 1'b0, "R2 others wait");
      step(3);
      req = 4'b0110;
      expect_at(1, 4'b0000, 1'b0, "R4 release gap");
      expect_at(2, 4'b0010, 1'b0, "R6 port1 before boot");
      step(3);
      req = 4'b0100;
      expect_at(1, 4'b0000, 1'b0, "R4 release gap");
      expect_at(2, 4'b0100, 1'b0, "R4 next waiter");
      step(3);
      req = 4'b0000;
      expect_at(1, 4'b0000, 1'b0, "R4 release");
      step(3);

      // R6: firmware beats port 0
      req = 4'b1001;
      expect_at(1, 4'b1000, 1'b0, "R6 firmware first");
      step(3);
      req = 4'b0000;
      expect_at(1, 4'b0000, 1'b0, "R4 release");
      step(3);

      // R5: arrival order beats priority
      req = 4'b0100;
      expect_at(1, 4'b0100, 1'b0, "R3 boot granted");
      step(2);
      req = 4'b0110;
      step(2);
      req = 4'b0111;
      step(2);
      req = 4'b1111;
      expect_at(1, 4'b0100, 1'b0, "R2 holder keeps lock");
      expect_at(2, 4'b0100, 1'b0, "R2 holder keeps lock");
      step(3);
      req = 4'b1011;
      expect_at(1, 4'b0000, 1'b0, "R4 release gap");
      expect_at(2, 4'b0010, 1'b0, "R5 oldest port1");
      step(3);
      req = 4'b1001;
      expect_at(1, 4'b0000, 1'b0, "R4 release gap");
      expect_at(2, 4'b0001, 1'b0, "R5 port0 before firmware");
      step(3);
      req = 4'b1000;
      expect_at(1, 4'b0000, 1'b0, "R4 release gap");
      expect_at(2, 4'b1000, 1'b0, "R5 firmware last");
      step(3);
      req = 4'b0000;
      expect_at(1, 4'b0000, 1'b0, "R4 release");
      step(3);

      // R7, R9: timeout while a non-holder toggles
      en  = 1'b1;
      tog = 4'b0110;
      req = 4'b0001;
      expect_at(1,     4'b0001, 1'b0, "R3 port0 granted");
      expect_at(T,     4'b0001, 1'b0, "R9 still held");
      expect_at(T + 1, 4'b0000, 1'b1, "R7 revoked with pulse");
      expect_at(T + 2, 4'b0000, 1'b0, "R7 pulse one cycle");
      expect_at(T + 6, 4'b0000, 1'b0, "R11 no regrant");
      step(T + 6);

      // R11: drop and reassert
      tog = 4'b0000;
      req = 4'b0000;
      step(1);
      req = 4'b0001;
      expect_at(1, 4'b0001, 1'b0, "R11 regrant after drop");
      step(10);

      // R8: holder strobe restarts the count
      tog = 4'b0001;
      expect_at(T,     4'b0001, 1'b0, "R8 held after reload");
      expect_at(T + 1, 4'b0000, 1'b1, "R8 revoked after reload");
      step(1);
      tog = 4'b0000;
      step(T + 1);
      req = 4'b0000;
      step(2);

      // R10: no revocation with enable low
      en  = 1'b0;
      req = 4'b0010;
      expect_at(1,     4'b0010, 1'b0, "R3 port1 granted");
      expect_at(3 * T, 4'b0010, 1'b0, "R10 grant kept");
      step(3 * T + 1);
      req = 4'b0000;
      expect_at(1, 4'b0000, 1'b0, "R4 release");
      step(3);

      if (sb.size() != 0) begin
         n_cmp++;
         n_bad++;
         $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
      end
      summary();
      $finish;
   end

endmodule